// File: doc/BRIEF.md
# Sliding Ramp Code Generator

This block produces the digital staircase for the fine, single-slope phase of a hybrid converter whose coarse bits come from successive approximation. A small counter steps through every fine code, one per clock, while the active-low window input is held low. It stops at the top code and clears whenever the window is closed.

A lane multiplexer places the fine code onto a six-line field of low DAC control lines. Where the code lands depends on a two-bit resolution mode. At the lowest resolution the code sits at the top of the field and the bottom lines are grounded. At each higher resolution the code moves down one line, and the top line it frees is taken over by one of the two least significant coarse bits. One mode code is unassigned and silences the whole field. The raw fine code is also brought out unchanged, so the capture logic downstream can latch it when the comparator toggles.

Top module: `ramp_shift_gen`

## Requirements
- R1: While `rst_n` is low, `ramp_code` reads 0000 at once, without waiting for a clock edge.
- R2: On a rising clock edge with `ramp_en_n` high, `ramp_code` becomes 0000.
- R3: On a rising clock edge with `ramp_en_n` low and `ramp_code` below 1111, `ramp_code` goes up by exactly one.
- R4: On a rising clock edge with `ramp_en_n` low and `ramp_code` at 1111, `ramp_code` stays at 1111. It does not wrap.
- R5: With `mode` = 2'b00, `q[5:2]` equals `ramp_code` (bit 3 on `q[5]`) and `q[1:0]` is 00.
- R6: With `mode` = 2'b10, `q[5]` equals `sar_s1`, `q[4:1]` equals `ramp_code` and `q[0]` is 0.
- R7: With `mode` = 2'b11, `q[5]` equals `sar_s1`, `q[4]` equals `sar_s0` and `q[3:0]` equals `ramp_code`.
- R8: With `mode` = 2'b01, all six bits of `q` are 0.
- R9: A coarse bit that the current mode does not map has no effect on `q`: `sar_s1` and `sar_s0` in mode 00, `sar_s0` in mode 10, and both in mode 01. `q` follows `mode`, `sar_s1` and `sar_s0` in the same cycle, with no clock edge between.
- R10: `ramp_code` counts by R2 to R4 in every mode, including 01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Release is taken in through two flops. |
| ramp_en_n | input | 1 | Active-low fine-conversion window |
| mode | input | 2 | Resolution mode: 00 low, 10 middle, 11 full, 01 off |
| sar_s1 | input | 1 | Coarse bit one above the coarse LSB |
| sar_s0 | input | 1 | Coarse LSB |
| q | output | 6 | Low DAC control field |
| ramp_code | output | 4 | Raw fine ramp code |

## Verification
A counter that skips, repeats, wraps or fails to clear shows up on `ramp_code` in the cycle after the clock edge that was wrong. Long open windows push the count into saturation again and again, and short closed gaps test the clear. A wrong lane selection or a stale coarse bit shows on `q` in the same cycle, because the lane path holds no state. The mode and coarse bits are therefore changed away from the edge and `q` is checked right after each change. An asynchronous reset issued in the middle of a ramp shows whether the clear arrives without a clock.

// File: rtl/ramp_shift_pkg.sv
package ramp_shift_pkg;

  // Resolution modes; the encoding is fixed by the external select pins.
  typedef enum logic [1:0] {
    MODE_LOW  = 2'b00,
    MODE_OFF  = 2'b01,
    MODE_MID  = 2'b10,
    MODE_FULL = 2'b11
  } ramp_mode_e;

  localparam int unsigned DEF_CODE_W = 4;
  localparam int unsigned DEF_SAR_W  = 2;

endpackage

// File: rtl/ramp_rst_sync.sv
module ramp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/ramp_counter.sv
module ramp_counter #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ramp_en_n,
  output logic [CODE_W-1:0] code
);

  localparam logic [CODE_W-1:0] CODE_MAX  = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_ZERO = '0;

  logic [CODE_W-1:0] cnt_q;
  logic [CODE_W-1:0] cnt_d;
  logic              cnt_en;

  // next state: clear outside the window, climb inside, stop at the top
  always_comb begin
    cnt_d = cnt_q;
    if (ramp_en_n) begin
      cnt_d = CODE_ZERO;
    end else if (cnt_q != CODE_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  // explicit clock enable: update only when the value has to move
  always_comb begin
    if (ramp_en_n) begin
      cnt_en = (cnt_q != CODE_ZERO);
    end else begin
      cnt_en = (cnt_q != CODE_MAX);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CODE_ZERO;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign code = cnt_q;

  // R2
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_en_n |=> (code == CODE_ZERO));

  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ramp_en_n && code != CODE_MAX) |=> (code == CODE_W'($past(code) + 1'b1)));

  // R4
  top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ramp_en_n && code == CODE_MAX) |=> (code == CODE_MAX));

endmodule

// File: rtl/ramp_mode_decode.sv
module ramp_mode_decode
  import ramp_shift_pkg::*;
#(
  parameter int unsigned SAR_W = 2,
  localparam int unsigned SH_W = $clog2(SAR_W + 1)
) (
  input  ramp_mode_e       mode,
  output logic [SH_W-1:0]  shift_amt,
  output logic             active
);

  // shift = number of grounded bottom lines below the ramp code
  always_comb begin
    shift_amt = '0;
    active    = 1'b1;
    unique case (mode)
      MODE_LOW:  shift_amt = SH_W'(SAR_W);
      MODE_MID:  shift_amt = SH_W'(SAR_W - 1);
      MODE_FULL: shift_amt = '0;
      default:   active    = 1'b0;
    endcase
  end

endmodule

// File: rtl/ramp_lane_mux.sv
module ramp_lane_mux
  import ramp_shift_pkg::*;
#(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned SAR_W  = 2,
  localparam int unsigned FIELD_W = CODE_W + SAR_W,
  localparam int unsigned SH_W    = $clog2(SAR_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ramp_mode_e         mode,
  input  logic [CODE_W-1:0]  code,
  input  logic [SAR_W-1:0]   sar,
  input  logic [SH_W-1:0]    shift_amt,
  input  logic               active,
  output logic [FIELD_W-1:0] q
);

  logic [FIELD_W-1:0] shifted;
  logic [FIELD_W-1:0] lane;

  assign shifted = {{SAR_W{1'b0}}, code} << shift_amt;

  for (genvar i = 0; i < FIELD_W; i++) begin : g_lane
    if (i >= CODE_W) begin : g_upper
      // an upper line carries a coarse bit once the code has slid below it
      assign lane[i] = ((int'(shift_amt) + CODE_W) <= i) ? sar[i-CODE_W] : shifted[i];
    end else begin : g_lower
      assign lane[i] = shifted[i];
    end
  end

  assign q = lane & {FIELD_W{active}};

  // R8
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF) |-> (q == '0));

  // R5
  low_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LOW) |-> (q == {code, {SAR_W{1'b0}}}));

  // R6
  mid_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_MID) |-> (q == {sar[SAR_W-1:1], code, 1'b0}));

  // R7
  full_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FULL) |-> (q == {sar, code}));

endmodule

// File: rtl/ramp_shift_gen.sv
module ramp_shift_gen
  import ramp_shift_pkg::*;
#(
  parameter int unsigned CODE_W = DEF_CODE_W,
  parameter int unsigned SAR_W  = DEF_SAR_W,
  localparam int unsigned FIELD_W = CODE_W + SAR_W,
  localparam int unsigned SH_W    = $clog2(SAR_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ramp_en_n,
  input  logic [1:0]         mode,
  input  logic               sar_s1,
  input  logic               sar_s0,
  output logic [FIELD_W-1:0] q,
  output logic [CODE_W-1:0]  ramp_code
);

  logic             rst_n_int;
  logic [SH_W-1:0]  shift_amt;
  logic             active;
  ramp_mode_e       mode_e;
  logic [SAR_W-1:0] sar_bits;

  assign mode_e   = ramp_mode_e'(mode);
  assign sar_bits = {sar_s1, sar_s0};

  ramp_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ramp_counter #(.CODE_W(CODE_W)) i_counter (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .ramp_en_n (ramp_en_n),
    .code      (ramp_code)
  );

  ramp_mode_decode #(.SAR_W(SAR_W)) i_decode (
    .mode      (mode_e),
    .shift_amt (shift_amt),
    .active    (active)
  );

  ramp_lane_mux #(.CODE_W(CODE_W), .SAR_W(SAR_W)) i_lane_mux (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .mode      (mode_e),
    .code      (ramp_code),
    .sar       (sar_bits),
    .shift_amt (shift_amt),
    .active    (active),
    .q         (q)
  );

  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_n_int |-> (ramp_code == '0));

endmodule

// File: tb/test_ramp_shift_gen.sv
module test_ramp_shift_gen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ramp_en_n;
  logic [1:0] mode;
  logic       sar_s1;
  logic       sar_s0;
  logic [5:0] q;
  logic [3:0] ramp_code;

  int checks = 0;
  int errors = 0;
  int m_cnt  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ramp_shift_gen i_ramp_shift_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .ramp_en_n (ramp_en_n),
    .mode      (mode),
    .sar_s1    (sar_s1),
    .sar_s0    (sar_s0),
    .q         (q),
    .ramp_code (ramp_code)
  );

  function automatic logic [5:0] exp_q(int c, logic [1:0] md, logic s1, logic s0);
    logic [3:0] cc;
    cc = c[3:0];
    case (md)
      2'b00:   return {cc, 2'b00};
      2'b10:   return {s1, cc, 1'b0};
      2'b11:   return {s1, s0, cc};
      default: return 6'b000000;
    endcase
  endfunction

  function automatic string q_tag(logic [1:0] md);
    case (md)
      2'b00:   return "R5";
      2'b10:   return "R6";
      2'b11:   return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: check count, drive, check lanes, then advance the model
  task automatic step(logic en_v, logic [1:0] md, logic s1v, logic s0v);
    string ctag;
    @(negedge clk);
    if (ramp_en_n)        ctag = "R2";
    else if (mode == 2'b01) ctag = "R10";
    else if (m_cnt == 15) ctag = "R4";
    else                  ctag = "R3";
    chk(ctag, int'(ramp_code), m_cnt);
    ramp_en_n = en_v;
    mode      = md;
    sar_s1    = s1v;
    sar_s0    = s0v;
    #1;
    chk(q_tag(md), int'(q), int'(exp_q(m_cnt, md, s1v, s0v)));
    @(posedge clk);
    if (!rst_n || ramp_en_n) m_cnt = 0;
    else if (m_cnt < 15)     m_cnt = m_cnt + 1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] qa;
    void'($urandom(32'd1234));
    rst_n = 1'b0; ramp_en_n = 1'b1; mode = 2'b11; sar_s1 = 1'b1; sar_s0 = 1'b1;
    #25;
    // R1: reset state
    chk("R1", int'(ramp_code), 0);
    chk("R7", int'(q), 6'b110000);
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 3; k++) step(1'b1, 2'b00, 1'b0, 1'b0);

    // directed: full ramp in each mode, past saturation
    for (int k = 0; k < 20; k++) step(1'b0, 2'b00, k[0], k[1]);
    step(1'b1, 2'b00, 1'b1, 1'b1);
    for (int k = 0; k < 20; k++) step(1'b0, 2'b10, k[1], k[0]);
    step(1'b1, 2'b10, 1'b0, 1'b1);
    for (int k = 0; k < 20; k++) step(1'b0, 2'b11, k[2], k[0]);
    step(1'b1, 2'b11, 1'b1, 1'b0);
    // R10: counting continues in the off mode
    for (int k = 0; k < 18; k++) step(1'b0, 2'b01, 1'b1, 1'b1);
    step(1'b1, 2'b01, 1'b0, 1'b0);

    // R9: unmapped coarse bits have no effect on q
    for (int k = 0; k < 6; k++) step(1'b0, 2'b00, 1'b0, 1'b0);
    @(negedge clk);
    mode = 2'b00; sar_s1 = 1'b0; sar_s0 = 1'b0; #1; qa = q;
    sar_s1 = 1'b1; sar_s0 = 1'b1; #1;
    chk("R9", int'(q), int'(qa));
    mode = 2'b10; sar_s0 = 1'b0; #1; qa = q;
    sar_s0 = 1'b1; #1;
    chk("R9", int'(q), int'(qa));
    mode = 2'b01; #1;
    chk("R9", int'(q), 0);
    @(posedge clk);
    if (m_cnt < 15) m_cnt = m_cnt + 1;

    // R1: asynchronous reset in the middle of a ramp
    @(negedge clk);
    rst_n = 1'b0; #1;
    chk("R1", int'(ramp_code), 0);
    ramp_en_n = 1'b1; m_cnt = 0;
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 3; k++) step(1'b1, 2'b11, 1'b0, 1'b1);

    // constrained random windows with random mode and coarse bits
    for (int f = 0; f < 60; f++) begin
      int len;
      int gap;
      len = 3 + int'($urandom_range(22));
      gap = 1 + int'($urandom_range(3));
      for (int k = 0; k < len; k++)
        step(1'b0, 2'($urandom_range(3)), 1'($urandom_range(1)), 1'($urandom_range(1)));
      for (int k = 0; k < gap; k++)
        step(1'b1, 2'($urandom_range(3)), 1'($urandom_range(1)), 1'($urandom_range(1)));
    end
    step(1'b1, 2'b00, 1'b0, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule